// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a serial-peripheral master for one attached device. A processor programs a control byte that selects the serial clock rate, the idle level of the clock, the clock phase, an 8-bit or 16-bit frame, and the bit order. Data then moves through a one-word data port. A write to the port fills a single transmit holding register. A finished frame fills a single receive holding register. Four flags report the state of the block: transmit empty, receive full, busy and overrun.

A frame begins when the holding register is full and the block is enabled. The controller pulls chip-select low, generates the clock edges, shifts data out on MOSI and captures MISO. If the processor refills the holding register before the last edge of a frame, the next frame follows straight on. Chip-select stays low and the clock keeps the same spacing. When nothing is pending after the last edge, chip-select is released half a clock period later.

Top module: `spi_master`

## Requirements
- R1: The control byte is laid out as bits [2:0] rate code, [3] clock idle level, [4] phase, [5] 16-bit frame, [6] LSB first, [7] enable. A control write is ignored while a transfer is busy or about to start, so frame shape and clock level stay unchanged until the block is idle.
- R2: Each SCK half-period is 2^code system clocks, so one full SCK period is 2^(code+1) clocks. Consecutive SCK edges are exactly one half-period apart.
- R3: While chip-select is high, SCK rests at the programmed idle level.
- R4: With phase 0, the first data bit is on MOSI when chip-select falls. MISO is captured on the odd-numbered SCK edges (1st, 3rd, ...) and MOSI changes on the even-numbered ones.
- R5: With phase 1, MOSI changes on the odd-numbered SCK edges (1st, 3rd, ...) and MISO is captured on the even-numbered ones.
- R6: A frame has 8 or 16 bits (16 SCK edges or 32 SCK edges). After an 8-bit frame, bits [15:8] of the read data are zero.
- R7: With LSB first clear, bit N-1 of the word goes out first and the first received bit lands in bit N-1. With LSB first set, bit 0 goes out first and the first received bit lands in bit 0.
- R8: Transmit-empty drops in the cycle after a data write. It returns once the word has moved into the shifter.
- R9: Receive-full rises at the end of a frame, with the received word on the read-data port. It falls after a data read.
- R10: Busy is high from frame start until chip-select is released.
- R11: A frame that completes while receive-full is set raises overrun, and its data is discarded: the older word stays readable. Overrun clears only when a status read is followed by a data read. A data read alone leaves it set.
- R12: Chip-select falls one half-period before the first SCK edge and rises one half-period after the last one. A word written before a frame ends is sent with no gap and without releasing chip-select.
- R13: While enable is clear, a written word is held and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte (layout in R1) |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 16 | Word to transmit (low byte in 8-bit mode) |
| dat_re | input | 1 | Data port read strobe |
| dat_rdata | output | 16 | Last received word |
| sts_re | input | 1 | Status read strobe (first step of overrun clear) |
| txe | output | 1 | Transmit holding register empty |
| rxne | output | 1 | Receive holding register full |
| bsy | output | 1 | Transfer in progress |
| ovr | output | 1 | Overrun flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip-select |
| miso | input | 1 | Serial data in |

## Verification
An off-by-one in the half-period counter shows at the very first SCK edge: the spacing after chip-select falls no longer equals 2^code clocks. An edge counter that miscounts has two possible symptoms. It can leave chip-select rising in mid-frame. It can also shift a received word by one bit, which shows as soon as receive-full rises. A phase or bit-order fault garbles the word the attached device receives within the first frame. A wrong flag update shows one cycle after the strobe that should have moved it. Because the peripheral model is rebuilt from the port pins each frame, a fault that corrupts the reloaded word shows within one frame.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int FRAME_W = 16;
  localparam int HALF_W  = FRAME_W / 2;
  localparam int RATE_W  = 3;

  typedef struct packed {
    logic              en;
    logic              lsb_first;
    logic              wide;
    logic              cpha;
    logic              cpol;
    logic [RATE_W-1:0] rate;
  } spi_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_TAIL} spi_state_e;

  // Normalise a word: mirror the active bits for LSB-first order, zero
  // the upper half in narrow mode.
  function automatic logic [FRAME_W-1:0] order_fix(input logic [FRAME_W-1:0] d,
                                                   input logic lsb, input logic wide);
    logic [FRAME_W-1:0] r;
    r = '0;
    if (!lsb) begin
      r = wide ? d : {{HALF_W{1'b0}}, d[HALF_W-1:0]};
    end else if (wide) begin
      for (int i = 0; i < FRAME_W; i++) r[i] = d[FRAME_W-1-i];
    end else begin
      for (int i = 0; i < HALF_W; i++) r[i] = d[HALF_W-1-i];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_rate_tick.sv
module spi_rate_tick #(
  parameter int RATE_W = 3,
  parameter int DIV_W  = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, half_m1;

  always_comb begin
    half_m1 = (DIV_W'(1) << rate) - DIV_W'(1);
    tick    = run && (cnt_q == half_m1);
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: counter never passes the half-period limit while running
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= half_m1));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_emit,
  input  logic [W-1:0] load_word,
  input  logic         emit,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_now,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic         mosi_q, mosi_d;

  always_comb begin
    tx_d    = tx_q;
    mosi_d  = mosi_q;
    rx_next = {rx_q[W-2:0], miso};
    rx_d    = sample ? rx_next : rx_q;
    if (load) begin
      if (load_emit) begin
        mosi_d = load_word[W-1];
        tx_d   = load_word << 1;
      end else begin
        tx_d   = load_word;
      end
    end else if (emit) begin
      mosi_d = tx_q[W-1];
      tx_d   = tx_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      mosi_q <= mosi_d;
    end
  end

  assign mosi   = mosi_q;
  assign rx_now = rx_q;

  // R4 / R5: MOSI only moves on a load or a drive edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !emit) |=> $stable(mosi));
endmodule

// File: rtl/spi_master.sv
module spi_master
  import spi_master_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  input  logic        dat_re,
  output logic [15:0] dat_rdata,
  input  logic        sts_re,
  output logic        txe,
  output logic        rxne,
  output logic        bsy,
  output logic        ovr,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int DIV_W  = 1 << RATE_W;
  localparam int EDGE_W = $clog2(2 * FRAME_W);

  spi_cfg_t            cfg_q, cfg_d;
  spi_state_e          state_q, state_d;
  logic [EDGE_W-1:0]   edge_q, edge_d, last_idx;
  logic [FRAME_W-1:0]  txbuf_q, txbuf_d, rxbuf_q, rxbuf_d;
  logic                txfull_q, txfull_d, rxne_q, rxne_d;
  logic                ovr_q, ovr_d, arm_q, arm_d, sck_q, sck_d;
  logic                tick, start, xfer_tick, at_last, reload, load;
  logic                emit, sample;
  logic [FRAME_W-1:0]  fixed_tx, load_word, rx_now, rx_next, rx_word;

  spi_rate_tick #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE),
    .rate(cfg_q.rate), .tick(tick));

  always_comb begin
    start     = (state_q == ST_IDLE) && txfull_q && cfg_q.en;
    xfer_tick = tick && (state_q == ST_XFER);
    last_idx  = cfg_q.wide ? EDGE_W'(2*FRAME_W-1) : EDGE_W'(FRAME_W-1);
    at_last   = xfer_tick && (edge_q == last_idx);
    reload    = at_last && txfull_q && cfg_q.en;
    load      = start || reload;
    emit      = xfer_tick && (edge_q[0] != cfg_q.cpha) && (edge_q != last_idx);
    sample    = xfer_tick && (edge_q[0] == cfg_q.cpha);
    fixed_tx  = order_fix(txbuf_q, cfg_q.lsb_first, cfg_q.wide);
    load_word = cfg_q.wide ? fixed_tx : {fixed_tx[HALF_W-1:0], {HALF_W{1'b0}}};
    rx_word   = order_fix(cfg_q.cpha ? rx_next : rx_now, cfg_q.lsb_first, cfg_q.wide);
  end

  spi_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_emit(!cfg_q.cpha),
    .load_word(load_word), .emit(emit), .sample(sample), .miso(miso),
    .mosi(mosi), .rx_now(rx_now), .rx_next(rx_next));

  // Sequencing
  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    sck_d   = sck_q;
    case (state_q)
      ST_IDLE: begin
        sck_d = cfg_q.cpol;
        if (start) begin
          state_d = ST_XFER;
          edge_d  = '0;
        end
      end
      ST_XFER: begin
        if (xfer_tick) begin
          sck_d = ~sck_q;
          if (at_last) begin
            edge_d  = '0;
            state_d = reload ? ST_XFER : ST_TAIL;
          end else begin
            edge_d  = edge_q + EDGE_W'(1);
          end
        end
      end
      default: if (tick) state_d = ST_IDLE;
    endcase
  end

  // Buffers and flags
  always_comb begin
    cfg_d    = (cfg_we && (state_q == ST_IDLE) && !start) ? spi_cfg_t'(cfg_wdata) : cfg_q;
    txfull_d = (txfull_q && !load) || dat_we;
    txbuf_d  = dat_we ? dat_wdata : txbuf_q;
    rxbuf_d  = rxbuf_q;
    rxne_d   = rxne_q && !dat_re;
    ovr_d    = ovr_q;
    arm_d    = arm_q;
    if (sts_re && ovr_q) arm_d = 1'b1;
    if (dat_re && arm_q) begin
      ovr_d = 1'b0;
      arm_d = 1'b0;
    end
    if (at_last) begin
      if (rxne_q) begin
        ovr_d = 1'b1;
      end else begin
        rxbuf_d = rx_word;
        rxne_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      state_q  <= ST_IDLE;
      edge_q   <= '0;
      sck_q    <= 1'b0;
      txbuf_q  <= '0;
      txfull_q <= 1'b0;
      rxbuf_q  <= '0;
      rxne_q   <= 1'b0;
      ovr_q    <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      state_q  <= state_d;
      edge_q   <= edge_d;
      sck_q    <= sck_d;
      txbuf_q  <= txbuf_d;
      txfull_q <= txfull_d;
      rxbuf_q  <= rxbuf_d;
      rxne_q   <= rxne_d;
      ovr_q    <= ovr_d;
      arm_q    <= arm_d;
    end
  end

  assign dat_rdata = rxbuf_q;
  assign txe       = !txfull_q;
  assign rxne      = rxne_q;
  assign bsy       = (state_q != ST_IDLE);
  assign ovr       = ovr_q;
  assign sck       = sck_q;
  assign cs_n      = (state_q == ST_IDLE);

  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bsy |=> $stable(cfg_q));
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cfg_q.cpol)) |-> (sck == cfg_q.cpol));
  p_txe_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |=> !txe);
  p_cs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> bsy);
  p_ovr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && rxne) |=> (ovr && $stable(dat_rdata)));
endmodule

// File: tb/tb_spi_master.sv
module tb_spi_master;
  logic        clk, rst_n;
  logic        cfg_we, dat_we, dat_re, sts_re, miso;
  logic [7:0]  cfg_wdata;
  logic [15:0] dat_wdata, dat_rdata;
  logic        txe, rxne, bsy, ovr, sck, mosi, cs_n;

  int checks, fails, run_id;
  int cur_h, cur_n;
  bit cur_cpha, cur_lsb, finished;
  int cs_falls, fidx, ecnt, gap;
  logic cs_prev, sck_prev;
  logic [15:0] rcv;

  spi_master dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mword(input int r, input int i);
    return 16'h9A3C ^ 16'(r * 16'h0457) ^ 16'(i * 16'h2B1);
  endfunction
  function automatic logic [15:0] sword(input int r, input int i);
    return 16'h5E71 ^ 16'(r * 16'h0931) ^ 16'(i * 16'h7707);
  endfunction
  // first bit on the wire sits at index n-1
  function automatic logic [15:0] wire_of(input logic [15:0] d, input int n, input bit lsb);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w[lsb ? n-1-i : i] = d[i];
    return w;
  endfunction
  function automatic logic [15:0] exp_rd(input logic [15:0] s, input int n);
    return (n == 8) ? {8'h00, s[7:0]} : s;
  endfunction

  // Peripheral model built from the pins
  always @(negedge clk) begin
    logic [15:0] w;
    if (!rst_n) begin
      cs_prev = 1'b1; sck_prev = 1'b0; miso = 1'b0;
      ecnt = 0; gap = 0; rcv = '0;
    end else begin
      if (cs_prev && !cs_n) begin
        cs_falls++; gap = 0; ecnt = 0; rcv = '0;
        w = wire_of(sword(run_id, fidx), cur_n, cur_lsb);
        if (!cur_cpha) miso = w[cur_n-1];
      end else if (!cs_n) begin
        gap++;
        if (sck !== sck_prev) begin
          check(gap == cur_h, (ecnt == 0) ? "R12 lead half-period" : "R2 edge spacing", gap, cur_h);
          gap = 0;
          w = wire_of(sword(run_id, fidx), cur_n, cur_lsb);
          if (ecnt[0] == cur_cpha) rcv = {rcv[14:0], mosi};
          else if (cur_cpha) miso = w[cur_n-1-ecnt/2];
          else if ((ecnt+1)/2 < cur_n) miso = w[cur_n-1-(ecnt+1)/2];
          ecnt++;
          if (ecnt == 2*cur_n) begin
            w = wire_of(mword(run_id, fidx), cur_n, cur_lsb);
            check(((cur_n == 16) ? rcv : {8'h00, rcv[7:0]}) == w,
                  "R4/R5/R7 mosi bit order", rcv, w);
            fidx++; ecnt = 0;
            w = wire_of(sword(run_id, fidx), cur_n, cur_lsb);
            if (!cur_cpha) miso = w[cur_n-1];
          end
        end
      end else if (!cs_prev && cs_n) begin
        gap++;
        check(gap == cur_h, "R12 tail half-period", gap, cur_h);
        check(ecnt == 0, "R6 whole frames only", ecnt, 0);
      end
      cs_prev = cs_n; sck_prev = sck;
    end
  end

  task automatic pulse_cfg(input logic [7:0] v);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
    @(negedge clk) cfg_we = 1'b0;
  endtask
  task automatic pulse_wr(input logic [15:0] v);
    @(negedge clk) begin dat_we = 1'b1; dat_wdata = v; end
    @(negedge clk) dat_we = 1'b0;
  endtask
  task automatic pulse_rd();
    @(negedge clk) dat_re = 1'b1;
    @(negedge clk) dat_re = 1'b0;
  endtask
  task automatic pulse_sts();
    @(negedge clk) sts_re = 1'b1;
    @(negedge clk) sts_re = 1'b0;
  endtask
  task automatic wait_rxne();
    while (!rxne) @(negedge clk);
  endtask
  task automatic wait_idle();
    while (bsy) @(negedge clk);
  endtask

  task automatic setup(input int rate, input bit cpol, input bit cpha, input bit wide, input bit lsb);
    run_id++; fidx = 0; cs_falls = 0;
    cur_h = 1 << rate; cur_n = wide ? 16 : 8; cur_cpha = cpha; cur_lsb = lsb;
    pulse_cfg({1'b1, lsb, wide, cpha, cpol, 3'(rate)});
    @(negedge clk);
    check(sck == cpol, "R3 idle level", sck, cpol);
  endtask

  task automatic run_pair(input int rate, input bit cpol, input bit cpha, input bit wide, input bit lsb);
    setup(rate, cpol, cpha, wide, lsb);
    pulse_wr(mword(run_id, 0));
    check(txe == 1'b0, "R8 txe drop", txe, 0);
    @(negedge clk);
    check(txe && bsy && !cs_n, "R8/R10 load and busy", {txe, bsy, cs_n}, 3'b110);
    pulse_wr(mword(run_id, 1));
    wait_rxne();
    check(dat_rdata == exp_rd(sword(run_id, 0), cur_n), "R9/R6/R7 first word", dat_rdata, exp_rd(sword(run_id, 0), cur_n));
    pulse_rd();
    check(rxne == 1'b0, "R9 rxne cleared", rxne, 0);
    wait_rxne();
    check(dat_rdata == exp_rd(sword(run_id, 1), cur_n), "R9/R6/R7 second word", dat_rdata, exp_rd(sword(run_id, 1), cur_n));
    pulse_rd();
    wait_idle();
    @(negedge clk);
    check(cs_falls == 1 && fidx == 2, "R12 back-to-back under one select", cs_falls * 16 + fidx, 18);
    check(sck == cpol, "R3 idle after frames", sck, cpol);
  endtask

  initial begin
    checks = 0; fails = 0; run_id = 0; finished = 0;
    cur_h = 1; cur_n = 8; cur_cpha = 0; cur_lsb = 0; fidx = 0; cs_falls = 0;
    cfg_we = 0; dat_we = 0; dat_re = 0; sts_re = 0; cfg_wdata = '0; dat_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({txe, rxne, bsy, ovr, cs_n, sck} == 6'b100010, "R10/R8 reset state",
          {txe, rxne, bsy, ovr, cs_n, sck}, 6'b100010);

    // R2..R7, R12: sweep of modes over small rates
    for (int rate = 0; rate < 3; rate++)
      for (int m = 0; m < 16; m++)
        run_pair(rate, m[0], m[1], m[2], m[3]);
    run_pair(7, 1'b1, 1'b1, 1'b1, 1'b0);

    // R13: disabled block holds the word
    run_id++; fidx = 0; cs_falls = 0; cur_h = 2; cur_n = 8; cur_cpha = 0; cur_lsb = 0;
    pulse_cfg(8'h01);
    pulse_wr(mword(run_id, 0));
    repeat (20) @(negedge clk);
    check(!bsy && cs_n && !txe, "R13 no start while disabled", {bsy, cs_n, txe}, 3'b010);
    pulse_cfg(8'h81);
    @(negedge clk);
    check(!cs_n, "R13 start on enable", cs_n, 0);
    wait_rxne();
    check(dat_rdata == exp_rd(sword(run_id, 0), 8), "R13 word after enable", dat_rdata, exp_rd(sword(run_id, 0), 8));
    pulse_rd();
    wait_idle();

    // R1: control write during a frame has no effect
    setup(1, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse_wr(mword(run_id, 0));
    @(negedge clk);
    pulse_cfg(8'hD8);
    wait_rxne();
    check(dat_rdata == sword(run_id, 0), "R1 frame shape kept", dat_rdata, sword(run_id, 0));
    pulse_rd();
    wait_idle();
    repeat (2) @(negedge clk);
    check(sck == 1'b0, "R1 idle level kept", sck, 0);

    // R11: overrun set, discard and clear sequence
    setup(0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_wr(mword(run_id, 0));
    wait_rxne();
    wait_idle();
    pulse_wr(mword(run_id, 1));
    @(negedge clk);
    wait_idle();
    check(ovr == 1'b1, "R11 overrun raised", ovr, 1);
    check(dat_rdata == exp_rd(sword(run_id, 0), 8), "R11 older word kept", dat_rdata, exp_rd(sword(run_id, 0), 8));
    pulse_rd();
    check(ovr == 1'b1, "R11 data read alone keeps flag", ovr, 1);
    pulse_sts();
    pulse_rd();
    check(ovr == 1'b0, "R11 status then data clears", ovr, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule